// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is a cycle-accurate digital model of the feedback divider in a frequency synthesizer. The divider is built from a dual-modulus prescaler and two down-counters. Each clock of `clk` stands for one edge of the divided input signal. The prescaler counts input cycles in groups of P+1 or P. The swallow counter sets how many groups use the larger modulus. The main counter sets how many groups make up one output period. At the end of each output period the block raises the one-cycle `fp_pulse` output.

Software supplies a main count N, a swallow count A and a modulus-pair select, and strobes them in with `cfg_load`. The block checks each setting for legality and holds a legal one as pending. A pending setting takes effect only at the next output-period boundary, so no period is ever a mixture of an old setting and a new one. A period takes exactly P·N + A input cycles. The prescaler stays at P+1 for the first A groups of the period and uses P for the remaining N − A groups.

Top module: `psd_divider`

## Requirements
- R1: While reset is asserted `fp_pulse` is low. Out of reset the divider runs with N = 16, A = 0 and `cfg_sw` = 1, which gives a period of 1024 input cycles.
- R2: With a legal setting in force, successive rising edges of `fp_pulse` are exactly P·N + A cycles apart. P is 64 when `cfg_sw` = 1 and 128 when `cfg_sw` = 0.
- R3: The swallow count must stay below the main count. A load with A ≥ N is ignored, and the periods continue with the setting already held.
- R4: A load with N < 16 is ignored, and the periods continue with the setting already held.
- R5: With A = 0 every prescaler group uses modulus P, so the period is P·N.
- R6: At the largest legal swallow count, A = N − 1, the period is P·N + N − 1.
- R7: A setting loaded partway through a period does not change that period. It governs every period from the next boundary on.
- R8: `fp_pulse` is high for exactly one cycle in each period.
- R9: When several legal loads arrive within one period, only the last of them takes effect at the next boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input signal being divided. One rising edge is one input cycle. |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronized inside the block. |
| cfg_n | input | 11 | Main count N. Legal values are 16 to 2047. |
| cfg_a | input | 7 | Swallow count A. It must be less than N. |
| cfg_sw | input | 1 | Modulus pair select: 1 selects 64/65 and 0 selects 128/129. |
| cfg_load | input | 1 | Captures `cfg_n`, `cfg_a` and `cfg_sw` on a rising edge of `clk` when the setting is legal. |
| fp_pulse | output | 1 | One-cycle pulse marking the end of each output period. |

## Verification
The assertions assume that the held setting is always legal. That means N is at least 16 and A is below N, which keeps the swallow count below the main count at every step and keeps every period much longer than two cycles. The reset values satisfy this, and the legality check at the load input keeps any other setting out of the counters. The bench deliberately offers illegal settings to exercise that check. All of its loads are made one cycle after a pulse, well away from a boundary, so the effect of each load can be told apart by comparing the period in progress with the one after it.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;
  localparam int unsigned DEF_N_W   = 11;
  localparam int unsigned DEF_A_W   = 7;
  localparam int unsigned DEF_P_LO  = 64;
  localparam int unsigned DEF_P_HI  = 128;
  localparam int unsigned DEF_N_MIN = 16;

  function automatic int unsigned psd_base_mod(input bit sw_lo,
                                               input int unsigned p_lo,
                                               input int unsigned p_hi);
    return sw_lo ? p_lo : p_hi;
  endfunction
endpackage

// File: rtl/psd_cfg_hold.sv
`timescale 1ns/1ps
module psd_cfg_hold #(
  parameter int unsigned N_W    = 11,
  parameter int unsigned A_W    = 7,
  parameter int unsigned N_MIN  = 16,
  parameter int unsigned N_RST  = 16,
  parameter int unsigned A_RST  = 0,
  parameter bit          SW_RST = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [N_W-1:0] in_n,
  input  logic [A_W-1:0] in_a,
  input  logic           in_sw,
  input  logic           boundary,
  output logic [N_W-1:0] pend_n,
  output logic [A_W-1:0] pend_a,
  output logic           pend_sw,
  output logic           act_sw
);
  logic           n_ok, a_ok, accept;
  logic [N_W-1:0] pend_n_d;
  logic [A_W-1:0] pend_a_d;
  logic           pend_sw_d, act_sw_d;

  always_comb begin
    n_ok      = (in_n >= N_W'(N_MIN));
    a_ok      = (N_W'(in_a) < in_n);
    accept    = load && n_ok && a_ok;
    pend_n_d  = accept ? in_n  : pend_n;
    pend_a_d  = accept ? in_a  : pend_a;
    pend_sw_d = accept ? in_sw : pend_sw;
    act_sw_d  = boundary ? pend_sw : act_sw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_n  <= N_W'(N_RST);
      pend_a  <= A_W'(A_RST);
      pend_sw <= SW_RST;
      act_sw  <= SW_RST;
    end else begin
      pend_n  <= pend_n_d;
      pend_a  <= pend_a_d;
      pend_sw <= pend_sw_d;
      act_sw  <= act_sw_d;
    end
  end

  assert_short_n_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (in_n < N_W'(N_MIN))) |=> ($stable(pend_n) && $stable(pend_a) && $stable(pend_sw)));

  assert_big_a_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (N_W'(in_a) >= in_n)) |=> ($stable(pend_n) && $stable(pend_a) && $stable(pend_sw)));

  assert_sw_only_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(act_sw));
endmodule

// File: rtl/psd_prescaler.sv
`timescale 1ns/1ps
module psd_prescaler #(
  parameter int unsigned P_LO    = 64,
  parameter int unsigned P_HI    = 128,
  parameter int unsigned PC_W    = 8,
  parameter int unsigned CNT_RST = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_nx,
  input  logic swallow_nx,
  output logic pre_tc
);
  import psd_pkg::*;
  localparam logic [PC_W-1:0] MOD_LO = PC_W'(P_LO);
  localparam logic [PC_W-1:0] MOD_HI = PC_W'(P_HI);

  logic [PC_W-1:0] cnt_q, cnt_d, reload;

  always_comb begin
    pre_tc = (cnt_q == '0);
    reload = (sw_nx ? MOD_LO : MOD_HI) + PC_W'(swallow_nx) - PC_W'(1);
    cnt_d  = pre_tc ? reload : cnt_q - PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= PC_W'(CNT_RST);
    else        cnt_q <= cnt_d;
  end

  assert_group_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tc |=> ((cnt_q >= MOD_LO - PC_W'(1)) && (cnt_q <= MOD_HI)));
endmodule

// File: rtl/psd_swallow_ctr.sv
`timescale 1ns/1ps
module psd_swallow_ctr #(
  parameter int unsigned N_W   = 11,
  parameter int unsigned A_W   = 7,
  parameter int unsigned N_RST = 16,
  parameter int unsigned A_RST = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pre_tc,
  input  logic [N_W-1:0] ld_n,
  input  logic [A_W-1:0] ld_a,
  output logic           boundary,
  output logic           swallow_nx
);
  logic [N_W-1:0] n_q, n_d;
  logic [A_W-1:0] a_q, a_d;

  always_comb begin
    boundary = pre_tc && (n_q <= N_W'(1));
    n_d = n_q;
    a_d = a_q;
    if (boundary) begin
      n_d = ld_n;
      a_d = ld_a;
    end else if (pre_tc) begin
      n_d = n_q - N_W'(1);
      a_d = (a_q != '0) ? a_q - A_W'(1) : a_q;
    end
    swallow_nx = (a_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= N_W'(N_RST);
      a_q <= A_W'(A_RST);
    end else begin
      n_q <= n_d;
      a_q <= a_d;
    end
  end

  assert_swallow_below_main_R3: assert property (@(posedge clk) disable iff (!rst_n)
    N_W'(a_q) < n_q);

  assert_reload_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> ((n_q == $past(ld_n)) && (a_q == $past(ld_a))));

  assert_hold_between_groups_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_tc |=> ($stable(n_q) && $stable(a_q)));
endmodule

// File: rtl/psd_divider.sv
`timescale 1ns/1ps
module psd_divider #(
  parameter int unsigned N_W    = psd_pkg::DEF_N_W,
  parameter int unsigned A_W    = psd_pkg::DEF_A_W,
  parameter int unsigned P_LO   = psd_pkg::DEF_P_LO,
  parameter int unsigned P_HI   = psd_pkg::DEF_P_HI,
  parameter int unsigned N_MIN  = psd_pkg::DEF_N_MIN,
  parameter int unsigned N_RST  = 16,
  parameter int unsigned A_RST  = 0,
  parameter bit          SW_RST = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N_W-1:0] cfg_n,
  input  logic [A_W-1:0] cfg_a,
  input  logic           cfg_sw,
  input  logic           cfg_load,
  output logic           fp_pulse
);
  import psd_pkg::*;
  localparam int unsigned PC_W    = $clog2(P_HI + 1);
  localparam int unsigned CNT_RST = psd_base_mod(SW_RST, P_LO, P_HI)
                                    + ((A_RST != 0) ? 1 : 0) - 1;

  logic [1:0]     rst_sync;
  logic           rst_n_int;
  logic [N_W-1:0] pend_n;
  logic [A_W-1:0] pend_a;
  logic           pend_sw, act_sw, sw_nx;
  logic           pre_tc, boundary, swallow_nx;
  logic           fp_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  psd_cfg_hold #(
    .N_W(N_W), .A_W(A_W), .N_MIN(N_MIN),
    .N_RST(N_RST), .A_RST(A_RST), .SW_RST(SW_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n_int), .load(cfg_load),
    .in_n(cfg_n), .in_a(cfg_a), .in_sw(cfg_sw), .boundary(boundary),
    .pend_n(pend_n), .pend_a(pend_a), .pend_sw(pend_sw), .act_sw(act_sw)
  );

  assign sw_nx = boundary ? pend_sw : act_sw;

  psd_prescaler #(
    .P_LO(P_LO), .P_HI(P_HI), .PC_W(PC_W), .CNT_RST(CNT_RST)
  ) u_pre (
    .clk(clk), .rst_n(rst_n_int), .sw_nx(sw_nx),
    .swallow_nx(swallow_nx), .pre_tc(pre_tc)
  );

  psd_swallow_ctr #(
    .N_W(N_W), .A_W(A_W), .N_RST(N_RST), .A_RST(A_RST)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n_int), .pre_tc(pre_tc),
    .ld_n(pend_n), .ld_a(pend_a),
    .boundary(boundary), .swallow_nx(swallow_nx)
  );

  always_comb fp_d = boundary;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) fp_pulse <= 1'b0;
    else            fp_pulse <= fp_d;
  end

  assert_single_cycle_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    fp_pulse |=> !fp_pulse);

  always_comb begin
    if (!rst_n) assert_low_in_reset_R1: assert (!fp_pulse);
  end
endmodule

// File: tb/sim_psd_divider.sv
`timescale 1ns/1ps
module sim_psd_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] cfg_n = 11'd0;
  logic [6:0]  cfg_a = 7'd0;
  logic        cfg_sw = 1'b0;
  logic        cfg_load = 1'b0;
  logic        fp_pulse;

  int checks = 0;
  int fails  = 0;
  int cyc = 0;
  int fp_cnt = 0;
  int last_fp = 0;
  int prev_fp = 0;
  int wide_cnt = 0;
  bit fp_prev = 1'b0;
  bit done = 1'b0;

  psd_divider u0 (
    .clk(clk), .rst_n(rst_n), .cfg_n(cfg_n), .cfg_a(cfg_a),
    .cfg_sw(cfg_sw), .cfg_load(cfg_load), .fp_pulse(fp_pulse)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (fp_pulse && fp_prev) wide_cnt = wide_cnt + 1;
    if (fp_pulse) begin
      prev_fp = last_fp;
      last_fp = cyc;
      fp_cnt  = fp_cnt + 1;
    end
    fp_prev = fp_pulse;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_next(input int exp, input string req);
    int target;
    target = fp_cnt + 1;
    wait (fp_cnt == target);
    check((last_fp - prev_fp) == exp, req, last_fp - prev_fp, exp);
  endtask

  task automatic do_load(input int n, input int a, input bit sw);
    cfg_n = 11'(n); cfg_a = 7'(a); cfg_sw = sw; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    check(fp_pulse == 1'b0, "R1 reset low", int'(fp_pulse), 0);
    rst_n = 1'b1;
    wait (fp_cnt == 1);
    expect_next(1024, "R1 default period");
  endtask

  task automatic t_basic;
    do_load(20, 5, 1'b1);
    expect_next(1024, "R7 period in progress kept");
    expect_next(64*20 + 5, "R2 modulus 64/65");
  endtask

  task automatic t_sw;
    do_load(20, 5, 1'b0);
    expect_next(64*20 + 5, "R7 pair switch deferred");
    expect_next(128*20 + 5, "R2 modulus 128/129");
  endtask

  task automatic t_edge;
    do_load(16, 15, 1'b1);
    expect_next(128*20 + 5, "R7 old period kept");
    expect_next(64*16 + 15, "R6 A equals N-1");
    expect_next(64*16 + 15, "R6 repeated period");
  endtask

  task automatic t_zero_a;
    do_load(17, 0, 1'b0);
    expect_next(64*16 + 15, "R7 old period kept");
    expect_next(128*17, "R5 no swallow");
  endtask

  task automatic t_bad_a;
    do_load(18, 18, 1'b1);
    expect_next(128*17, "R3 A equal N ignored");
    expect_next(128*17, "R3 setting still held");
  endtask

  task automatic t_bad_n;
    do_load(15, 0, 1'b1);
    expect_next(128*17, "R4 short N ignored");
    expect_next(128*17, "R4 setting still held");
  endtask

  task automatic t_two_loads;
    cfg_n = 11'd16; cfg_a = 7'd1; cfg_sw = 1'b1; cfg_load = 1'b1;
    @(negedge clk);
    cfg_n = 11'd19; cfg_a = 7'd3; cfg_sw = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    expect_next(128*17, "R9 old period kept");
    expect_next(64*19 + 3, "R9 last load wins");
  endtask

  task automatic t_pulse;
    check(wide_cnt == 0, "R8 pulse width", wide_cnt, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_sw();
    t_edge();
    t_zero_a();
    t_bad_a();
    t_bad_n();
    t_two_loads();
    t_pulse();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule